// File: doc/BRIEF.md
# Single-Precision NaN Classify-and-Quiet Unit

This combinational unit inspects one 32-bit binary floating-point operand and sorts it into one of six classes: zero, subnormal, normal, infinity, quiet NaN or signaling NaN. It is meant to sit in front of the arithmetic datapath of a floating-point unit. There it decides early whether an operand needs special handling, and it turns a signaling NaN into its quiet form before the NaN travels further.

A mode input selects the polarity of the quiet indicator, which is the top fraction bit (bit 22). With `qset_quiet_i` high, a set indicator marks a quiet NaN. With it low, the legacy convention applies and a set indicator marks a signaling NaN. When the operand is a signaling NaN, the unit returns the quieted encoding and raises `invalid_o`. Legacy quieting clears the indicator. If that would leave the fraction at zero, which would encode an infinity, the unit sets fraction bit 21 as well. Every other operand leaves the unit unchanged with the flag low. The unit holds no state, has no clock and needs no reset.

Top module: `fpq_nan_quiet_unit`

## Requirements
- R1: `class_o` has exactly one bit set at all times, with positions 0 zero, 1 subnormal, 2 normal, 3 infinity, 4 quiet NaN, 5 signaling NaN.
- R2: A biased exponent of 0 selects class bit 0 when the fraction (bits 22..0) is zero, and class bit 1 when the fraction is nonzero.
- R3: A biased exponent (bits 30..23) from 1 to 254 selects class bit 2, whatever the fraction holds.
- R4: An exponent of 255 with a zero fraction selects class bit 3.
- R5: With `qset_quiet_i`=1, an exponent of 255 with a nonzero fraction is a quiet NaN (bit 4) when fraction bit 22 is 1, and a signaling NaN (bit 5) when fraction bit 22 is 0.
- R6: With `qset_quiet_i`=0, an exponent of 255 with a nonzero fraction is a signaling NaN when fraction bit 22 is 1, and a quiet NaN when fraction bit 22 is 0.
- R7: `invalid_o` is 1 exactly when the operand is classed as a signaling NaN.
- R8: With `qset_quiet_i`=1, quieting a signaling NaN sets bit 22 and leaves bits 21..0 unchanged.
- R9: With `qset_quiet_i`=0, quieting a signaling NaN clears bit 22. If bits 21..0 are then all zero, it sets bit 21. Otherwise it leaves bits 21..0 unchanged.
- R10: For any operand that is not a signaling NaN, `result_o` equals `operand_i`.
- R11: Bits 31..23 of `result_o` always equal those of `operand_i`.
- R12: When `invalid_o` is 1, `result_o` is a NaN that the active mode classes as quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Operand: sign bit 31, biased exponent 30..23, fraction 22..0 |
| qset_quiet_i | input | 1 | 1: a set bit 22 marks quiet; 0: legacy, a set bit 22 marks signaling |
| class_o | output | 6 | One-hot class vector |
| result_o | output | 32 | Operand, or its quieted form for a signaling NaN |
| invalid_o | output | 1 | Invalid-operation flag for a signaling NaN operand |

## Verification
All three outputs are combinational, so each result is due in the same cycle as the operand and mode that produce it, with zero register stages. The bench applies each new operand and mode just after a falling clock edge. It then waits a short settle delay, still well before the next rising edge, and compares `class_o`, `result_o` and `invalid_o` against a bench model. The next stimulus comes only after that sampling point, so each sample belongs to exactly one input pair.

// File: rtl/fpq_pkg.sv
package fpq_pkg;

    // Positions of the class vector bits
    typedef enum logic [2:0] {
        CLS_ZERO  = 3'd0,
        CLS_SUBN  = 3'd1,
        CLS_NORM  = 3'd2,
        CLS_INF   = 3'd3,
        CLS_QNAN  = 3'd4,
        CLS_SNAN  = 3'd5
    } fp_class_e;

    localparam int NUM_CLASSES = 6;

endpackage

// File: rtl/fpq_field_split.sv
module fpq_field_split #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WIDTH = 1 + EXP_W + FRAC_W
) (
    input  logic [WIDTH-1:0]  word_i,
    output logic              sign_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic              exp_zero_o,
    output logic              exp_ones_o,
    output logic              frac_zero_o,
    output logic              ind_bit_o
);

    assign sign_o      = word_i[WIDTH-1];
    assign exp_o       = word_i[WIDTH-2 -: EXP_W];
    assign frac_o      = word_i[FRAC_W-1:0];
    assign exp_zero_o  = (exp_o == '0);
    assign exp_ones_o  = (exp_o == '1);
    assign frac_zero_o = (frac_o == '0);
    assign ind_bit_o   = frac_o[FRAC_W-1];

endmodule

// File: rtl/fpq_classifier.sv
module fpq_classifier
    import fpq_pkg::*;
(
    input  logic                   exp_zero_i,
    input  logic                   exp_ones_i,
    input  logic                   frac_zero_i,
    input  logic                   ind_bit_i,
    input  logic                   qset_quiet_i,
    output logic [NUM_CLASSES-1:0] class_o,
    output logic                   is_snan_o
);

    fp_class_e cls;
    logic      signaling;

    // In the quiet-on-set mode a clear bit signals, in legacy a set bit does.
    assign signaling = qset_quiet_i ^ ind_bit_i;

    always_comb begin
        unique case ({exp_ones_i, exp_zero_i})
            2'b01:   cls = frac_zero_i ? CLS_ZERO : CLS_SUBN;
            2'b10: begin
                if (frac_zero_i)    cls = CLS_INF;
                else if (signaling) cls = CLS_SNAN;
                else                cls = CLS_QNAN;
            end
            default: cls = CLS_NORM;
        endcase
    end

    for (genvar gi = 0; gi < NUM_CLASSES; gi++) begin : g_onehot
        assign class_o[gi] = (cls == fp_class_e'(gi));
    end

    assign is_snan_o = (cls == CLS_SNAN);

endmodule

// File: rtl/fpq_quieter.sv
module fpq_quieter #(
    parameter int FRAC_W = 23
) (
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              qset_quiet_i,
    output logic [FRAC_W-1:0] frac_o
);

    localparam int LOW_W = FRAC_W - 1;
    localparam logic [LOW_W-1:0] FILL = LOW_W'(1) << (LOW_W - 1);

    logic [LOW_W-1:0] low;
    logic [LOW_W-1:0] legacy_low;

    assign low = frac_i[LOW_W-1:0];

    // Legacy quieting must not leave an all-zero fraction (infinity)
    assign legacy_low = (low == '0) ? FILL : low;

    always_comb begin
        if (qset_quiet_i) frac_o = {1'b1, low};
        else              frac_o = {1'b0, legacy_low};
    end

endmodule

// File: rtl/fpq_nan_quiet_unit.sv
module fpq_nan_quiet_unit
    import fpq_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WIDTH = 1 + EXP_W + FRAC_W
) (
    input  logic [WIDTH-1:0]       operand_i,
    input  logic                   qset_quiet_i,
    output logic [NUM_CLASSES-1:0] class_o,
    output logic [WIDTH-1:0]       result_o,
    output logic                   invalid_o
);

    logic              sign;
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac;
    logic              exp_zero, exp_ones, frac_zero, ind_bit;
    logic              is_snan;
    logic [FRAC_W-1:0] quiet_frac;

    fpq_field_split #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) split_i (
        .word_i      (operand_i),
        .sign_o      (sign),
        .exp_o       (exp_f),
        .frac_o      (frac),
        .exp_zero_o  (exp_zero),
        .exp_ones_o  (exp_ones),
        .frac_zero_o (frac_zero),
        .ind_bit_o   (ind_bit)
    );

    fpq_classifier class_i (
        .exp_zero_i   (exp_zero),
        .exp_ones_i   (exp_ones),
        .frac_zero_i  (frac_zero),
        .ind_bit_i    (ind_bit),
        .qset_quiet_i (qset_quiet_i),
        .class_o      (class_o),
        .is_snan_o    (is_snan)
    );

    fpq_quieter #(.FRAC_W(FRAC_W)) quiet_i (
        .frac_i       (frac),
        .qset_quiet_i (qset_quiet_i),
        .frac_o       (quiet_frac)
    );

    assign result_o  = is_snan ? {sign, exp_f, quiet_frac} : operand_i;
    assign invalid_o = is_snan;

endmodule

// File: rtl/fpq_nan_quiet_chk.sv
module fpq_nan_quiet_chk
    import fpq_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WIDTH = 1 + EXP_W + FRAC_W
) (
    input logic [WIDTH-1:0]       operand_i,
    input logic                   qset_quiet_i,
    input logic [NUM_CLASSES-1:0] class_o,
    input logic [WIDTH-1:0]       result_o,
    input logic                   invalid_o
);

    logic [EXP_W-1:0] r_exp;
    logic             r_ind;
    assign r_exp = result_o[WIDTH-2 -: EXP_W];
    assign r_ind = result_o[FRAC_W-1];

    always_comb begin
        assert_onehot_R1: assert ($countones(class_o) == 1)
            else $error("class vector not one-hot");
        assert_flag_class_R7: assert (invalid_o == class_o[CLS_SNAN])
            else $error("invalid flag disagrees with class");
        assert_passthru_R10: assert (invalid_o || result_o == operand_i)
            else $error("non-signaling operand altered");
        assert_hdr_kept_R11: assert (result_o[WIDTH-1:FRAC_W] == operand_i[WIDTH-1:FRAC_W])
            else $error("sign or exponent changed");
        assert_quiet_out_R12: assert (!invalid_o ||
            (r_exp == '1 && result_o[FRAC_W-1:0] != '0 && (r_ind ^ qset_quiet_i) == 1'b0))
            else $error("quieted result not a quiet NaN");
        assert_low_kept_R8: assert (!(invalid_o && qset_quiet_i) ||
            result_o[FRAC_W-2:0] == operand_i[FRAC_W-2:0])
            else $error("low fraction changed in quiet-on-set mode");
    end

endmodule

bind fpq_nan_quiet_unit fpq_nan_quiet_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (
    .operand_i    (operand_i),
    .qset_quiet_i (qset_quiet_i),
    .class_o      (class_o),
    .result_o     (result_o),
    .invalid_o    (invalid_o)
);

// File: tb/fpq_nan_quiet_unit_tb_top.sv
`timescale 1ns/1ps
module fpq_nan_quiet_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] operand;
    logic        mode;
    logic [5:0]  class_v;
    logic [31:0] result;
    logic        invalid;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    fpq_nan_quiet_unit dut_i (
        .operand_i    (operand),
        .qset_quiet_i (mode),
        .class_o      (class_v),
        .result_o     (result),
        .invalid_o    (invalid)
    );

    function automatic int model_class(input logic [31:0] x, input logic m);
        logic [7:0]  e = x[30:23];
        logic [22:0] f = x[22:0];
        if (e == 8'h00) return (f == 0) ? 0 : 1;
        if (e != 8'hFF) return 2;
        if (f == 0)     return 3;
        if (m) return x[22] ? 4 : 5;
        return x[22] ? 5 : 4;
    endfunction

    function automatic logic [31:0] model_result(input logic [31:0] x, input logic m);
        logic [31:0] y = x;
        if (model_class(x, m) != 5) return x;
        if (m) y[22] = 1'b1;
        else begin
            y[22] = 1'b0;
            if (y[21:0] == 0) y[21] = 1'b1;
        end
        return y;
    endfunction

    function automatic string tag_of(input int c, input logic m);
        case (c)
            0, 1:    return "R2";
            2:       return "R3";
            3:       return "R4";
            default: return m ? "R5" : "R6";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s op=%h mode=%0b got=%h exp=%h", tag, operand, mode, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] x, input logic m);
        int c;
        logic [31:0] er;
        @(negedge clk);
        operand = x;
        mode    = m;
        #1;
        c  = model_class(x, m);
        er = model_result(x, m);
        chk(tag_of(c, m), {26'd0, class_v}, 32'd1 << c);
        chk((c == 5) ? "R7" : "R1", {31'd0, invalid}, {31'd0, c == 5});
        if (c != 5)  chk("R10", result, er);
        else if (m)  chk("R8", result, er);
        else         chk("R9", result, er);
        chk("R11", {23'd0, result[31:23]}, {23'd0, x[31:23]});
        if (c == 5)
            chk("R12", {31'd0, (model_class(result, m) == 4)}, 32'd1);
    endtask

    initial begin
        operand = 32'h0;
        mode    = 1'b1;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset-state check: idle operand reads as +0, untouched
        chk("R2", {26'd0, class_v}, 32'd1);
        chk("R10", result, 32'h0);

        // directed corners
        apply(32'h8000_0000, 1'b1);
        apply(32'h0000_0001, 1'b0);
        apply(32'h0080_0000, 1'b1);
        apply(32'hFF00_0000, 1'b0);
        apply(32'h7F80_0000, 1'b1);
        apply(32'hFF80_0000, 1'b0);
        apply(32'h7FC0_0000, 1'b1);
        apply(32'h7F80_0001, 1'b1);
        apply(32'hFFBF_FFFF, 1'b1);
        apply(32'h7FC0_0000, 1'b0);
        apply(32'hFFC0_0000, 1'b0);
        apply(32'h7FC0_0001, 1'b0);
        apply(32'h7FFF_FFFF, 1'b0);
        apply(32'h7F80_0001, 1'b0);

        // constrained random
        void'($urandom(32'd20240607));
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] x = $urandom;
            int r = $urandom % 4;
            int s = $urandom % 4;
            if (r == 0) x[30:23] = 8'h00;
            else if (r == 1) x[30:23] = 8'hFF;
            if (s == 0) x[22:0] = 23'd0;
            else if (s == 1) x[22:0] = 23'h40_0000;
            else if (s == 2) x[22] = 1'b1;
            apply(x, 1'($urandom));
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule